// File: doc/BRIEF.md
# Bit Scan Unit

This is a purely combinational unit that locates a set bit inside a source operand. Given a direction select it reports either the lowest set position (upward scan, starting at bit 0) or the highest set position (downward scan, starting at the most significant bit of the operand). The operand may be 16 or 32 bits wide. In 16-bit mode the upper half of the source bus plays no part in the scan.

The unit also receives the value that the destination currently holds. When a set bit exists, the unit raises its found flag and its write-enable. It then presents the bit index, zero-extended to the destination width, as the new destination value. When no bit in the operand is set, the flag and the write-enable stay low and the destination value is passed through unchanged.

A datapath places the unit between its operand read ports and its register write port. Decoding of the operation and fetching of memory operands are handled elsewhere.

Top module: `bit_scan_unit`

## Requirements
- R1: With `scan_down_i` = 0 (upward), if any operand bit is set, `index_o` is the position of the lowest set bit of the operand. For example, 32-bit 00000001h gives 0, 00003000h gives 12, and 16-bit 00FFh gives 0.
- R2: With `scan_down_i` = 1 (downward), if any operand bit is set, `index_o` is the position of the highest set bit of the operand. For example, 16-bit 00FFh gives 7, 16-bit 8000h gives 15, and 32-bit 80000001h gives 31.
- R3: `found_o` is 0 whenever every bit of the operand is zero.
- R4: `found_o` is 1 whenever at least one operand bit is set, and `dest_we_o` always equals `found_o`.
- R5: When no operand bit is set, `dest_o` equals `dest_i`.
- R6: When a set bit is found, `dest_o` is `index_o` zero-extended to 32 bits.
- R7: With `wide_i` = 0 (16-bit operand), only `src_i[15:0]` is scanned and `src_i[31:16]` has no effect on any output. With `wide_i` = 1, all 32 bits are scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Source operand to scan |
| scan_down_i | input | 1 | 0 = upward scan from bit 0, 1 = downward scan from the top bit |
| wide_i | input | 1 | 0 = 16-bit operand, 1 = 32-bit operand |
| dest_i | input | 32 | Current destination value |
| index_o | output | 5 | Position of the found bit |
| found_o | output | 1 | High when the operand has at least one set bit |
| dest_we_o | output | 1 | Destination write-enable, equal to found_o |
| dest_o | output | 32 | Zero-extended index when found, otherwise dest_i |

## Verification
The hardest case to reach from the ports is a 16-bit operand whose upper source half is full of ones while its lower half is zero or sparse. In that case a scan that leaked past the operand size would return a wrong index or a false found flag. The stimulus table contains such operands in both directions, with distinct destination values so that any leak would show up. A walking single bit then covers every position in both sizes and both directions. Finally, a pseudo-random sweep is checked against a bench model that finds the lowest bit by isolating it and the highest bit by smearing it downward.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_dir_e;

  typedef enum logic {
    SIZE_NARROW = 1'b0,
    SIZE_WIDE   = 1'b1
  } op_size_e;
endpackage

// File: rtl/bscan_operand_mask.sv
module bscan_operand_mask #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] operand_o
);
  localparam int UPPER_W = DATA_W - NARROW_W;

  function automatic logic [DATA_W-1:0] size_mask(input logic wide);
    return {{UPPER_W{wide}}, {NARROW_W{1'b1}}};
  endfunction

  assign operand_o = raw_i & size_mask(wide_i);
endmodule

// File: rtl/bscan_prio_enc.sv
module bscan_prio_enc #(
  parameter int  W       = 32,
  parameter bit  FROM_TOP = 1'b0,
  localparam int IW      = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  function automatic logic [IW-1:0] lowest_one(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] highest_one(input logic [W-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  generate
    if (FROM_TOP) begin : g_down
      assign idx_o = highest_one(vec_i);
    end else begin : g_up
      assign idx_o = lowest_one(vec_i);
    end
  endgenerate

  assign any_o = |vec_i;
endmodule

// File: rtl/bscan_result_sel.sv
module bscan_result_sel #(
  parameter int  DATA_W = 32,
  localparam int IW     = $clog2(DATA_W)
) (
  input  logic              hit_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic [DATA_W-1:0] dest_o,
  output logic              we_o
);
  function automatic logic [DATA_W-1:0] widen(input logic [IW-1:0] idx);
    return {{(DATA_W - IW){1'b0}}, idx};
  endfunction

  assign dest_o = hit_i ? widen(idx_i) : dest_i;
  assign we_o   = hit_i;
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit
  import bscan_pkg::*;
#(
  parameter int  DATA_W   = 32,
  parameter int  NARROW_W = 16,
  localparam int IW       = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic              scan_down_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic [IW-1:0]     index_o,
  output logic              found_o,
  output logic              dest_we_o,
  output logic [DATA_W-1:0] dest_o
);
  scan_dir_e         dir;
  logic [DATA_W-1:0] operand;
  logic [IW-1:0]     idx_up;
  logic [IW-1:0]     idx_down;
  logic              hit_up;
  logic              hit_down;

  assign dir = scan_dir_e'(scan_down_i);

  bscan_operand_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_mask (
    .raw_i    (src_i),
    .wide_i   (wide_i),
    .operand_o(operand)
  );

  bscan_prio_enc #(.W(DATA_W), .FROM_TOP(1'b0)) u_up (
    .vec_i(operand),
    .idx_o(idx_up),
    .any_o(hit_up)
  );

  bscan_prio_enc #(.W(DATA_W), .FROM_TOP(1'b1)) u_down (
    .vec_i(operand),
    .idx_o(idx_down),
    .any_o(hit_down)
  );

  always_comb begin
    if (dir == SCAN_DOWN) begin
      index_o = idx_down;
      found_o = hit_down;
    end else begin
      index_o = idx_up;
      found_o = hit_up;
    end
  end

  bscan_result_sel #(.DATA_W(DATA_W)) u_sel (
    .hit_i (found_o),
    .idx_i (index_o),
    .dest_i(dest_i),
    .dest_o(dest_o),
    .we_o  (dest_we_o)
  );
endmodule

// File: rtl/bit_scan_unit_chk.sv
module bit_scan_unit_chk #(
  parameter int  DATA_W   = 32,
  parameter int  NARROW_W = 16,
  localparam int IW       = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] src_i,
  input logic              scan_down_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] dest_i,
  input logic [IW-1:0]     index_o,
  input logic              found_o,
  input logic              dest_we_o,
  input logic [DATA_W-1:0] dest_o
);
  logic [DATA_W-1:0] eff;
  logic [DATA_W-1:0] below;
  logic              known;

  assign eff   = src_i & {{(DATA_W - NARROW_W){wide_i}}, {NARROW_W{1'b1}}};
  assign below = (DATA_W'(1) << index_o) - DATA_W'(1);
  assign known = !$isunknown({src_i, scan_down_i, wide_i, dest_i});

  always_comb begin
    if (known) begin
      // R4
      we_tracks_found_chk: assert (dest_we_o == found_o);
      // R3
      zero_gives_no_hit_chk: assert ((eff == '0) == !found_o);
      // R5
      dest_held_chk: assert (found_o || dest_o == dest_i);
      // R6
      dest_index_chk: assert (!found_o || dest_o == DATA_W'(index_o));
      // R1
      up_lowest_chk: assert (!found_o || scan_down_i || (eff[index_o] && (eff & below) == '0));
      // R2
      down_highest_chk: assert (!found_o || !scan_down_i || ((eff >> index_o) == DATA_W'(1)));
      // R7
      narrow_range_chk: assert (wide_i || !found_o || index_o < IW'(NARROW_W));
    end
  end
endmodule

bind bit_scan_unit bit_scan_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .src_i      (src_i),
  .scan_down_i(scan_down_i),
  .wide_i     (wide_i),
  .dest_i     (dest_i),
  .index_o    (index_o),
  .found_o    (found_o),
  .dest_we_o  (dest_we_o),
  .dest_o     (dest_o)
);

// File: tb/tb_bit_scan_unit.sv
module tb_bit_scan_unit;
  logic        clk = 1'b0;
  logic [31:0] src_i = '0;
  logic        scan_down_i = 1'b0;
  logic        wide_i = 1'b1;
  logic [31:0] dest_i = '0;
  logic [4:0]  index_o;
  logic        found_o;
  logic        dest_we_o;
  logic [31:0] dest_o;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  bit_scan_unit dut (
    .src_i(src_i), .scan_down_i(scan_down_i), .wide_i(wide_i), .dest_i(dest_i),
    .index_o(index_o), .found_o(found_o), .dest_we_o(dest_we_o), .dest_o(dest_o)
  );

  typedef struct packed {
    logic        down;
    logic        wide;
    logic [31:0] src;
    logic [31:0] dest;
    logic        hit;
    logic [31:0] res;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 32'h0000_0001, 32'hAAAA_5555, 1'b1, 32'h0000_0000},
    '{1'b0, 1'b1, 32'h0000_3000, 32'h1111_2222, 1'b1, 32'h0000_000C},
    '{1'b0, 1'b0, 32'h0000_00FF, 32'h3333_4444, 1'b1, 32'h0000_0000},
    '{1'b1, 1'b0, 32'h0000_00FF, 32'h5555_6666, 1'b1, 32'h0000_0007},
    '{1'b1, 1'b0, 32'h0000_8000, 32'h7777_8888, 1'b1, 32'h0000_000F},
    '{1'b0, 1'b1, 32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF},
    '{1'b0, 1'b0, 32'hFFFF_0000, 32'h1234_5678, 1'b0, 32'h1234_5678},
    '{1'b1, 1'b0, 32'h8001_0000, 32'h9ABC_DEF0, 1'b0, 32'h9ABC_DEF0},
    '{1'b1, 1'b1, 32'h8000_0001, 32'h0F0F_0F0F, 1'b1, 32'h0000_001F},
    '{1'b1, 1'b1, 32'h0000_0000, 32'hCAFE_F00D, 1'b0, 32'hCAFE_F00D},
    '{1'b0, 1'b0, 32'h8001_8000, 32'h2468_ACE0, 1'b1, 32'h0000_000F},
    '{1'b1, 1'b0, 32'hFFFF_0001, 32'h1357_9BDF, 1'b1, 32'h0000_0000},
    '{1'b0, 1'b1, 32'h8000_0000, 32'hFEDC_BA98, 1'b1, 32'h0000_001F}
  };

  function automatic logic [5:0] model(input logic down, input logic wide, input logic [31:0] s);
    logic [31:0] v;
    logic [31:0] t;
    v = wide ? s : {16'h0, s[15:0]};
    if (v == 32'h0) return 6'h0;
    if (!down) begin
      t = v & (~v + 32'd1);
      return {1'b1, 5'($countones(t - 32'd1))};
    end
    t = v;
    t = t | (t >> 1);
    t = t | (t >> 2);
    t = t | (t >> 4);
    t = t | (t >> 8);
    t = t | (t >> 16);
    return {1'b1, 5'($countones(t) - 1)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (src=%h down=%b wide=%b)",
               req, act, exp, src_i, scan_down_i, wide_i);
    end
  endtask

  task automatic apply(input logic d, input logic w, input logic [31:0] s, input logic [31:0] de);
    @(negedge clk);
    scan_down_i = d;
    wide_i = w;
    src_i = s;
    dest_i = de;
    #5;
  endtask

  task automatic full_check(input string req, input logic exp_hit, input logic [31:0] exp_res);
    check({req, " found_o / R3 R4"}, 32'(found_o), 32'(exp_hit));
    check({req, " dest_we_o / R4"}, 32'(dest_we_o), 32'(exp_hit));
    check({req, " dest_o / R5 R6"}, dest_o, exp_res);
    if (exp_hit) check({req, " index_o / R6"}, 32'(index_o), exp_res);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [5:0]  m;
    // idle state: zero operand holds the destination (R3, R5)
    apply(1'b0, 1'b1, 32'h0, 32'h0BAD_F00D);
    full_check("R5 idle", 1'b0, 32'h0BAD_F00D);

    // table walk (R1, R2, R7)
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].down, VECS[k].wide, VECS[k].src, VECS[k].dest);
      full_check(VECS[k].down ? "R2 table" : "R1 table", VECS[k].hit, VECS[k].res);
    end

    // walking single bit: every position, both sizes, both directions (R1 R2 R7)
    for (int p = 0; p < 32; p++) begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < 2; w++) begin
          apply(d[0], w[0], 32'h1 << p, 32'h5A5A_0000 | 32'(p));
          if (w == 0 && p >= 16)
            full_check("R7 walk", 1'b0, 32'h5A5A_0000 | 32'(p));
          else
            full_check(d == 1 ? "R2 walk" : "R1 walk", 1'b1, 32'(p));
        end
      end
    end

    // upper half ignored when narrow: high half noise with a fixed low half (R7)
    for (int h = 0; h < 8; h++) begin
      apply(h[0], 1'b0, {16'(h * 16'h2F1D + 16'h8001), 16'h0410}, 32'hFACE_0000);
      full_check("R7 noise", 1'b1, h[0] ? 32'd10 : 32'd4);
    end

    // pseudo-random sweep against the bench model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[3], lfsr[7], lfsr & (lfsr >> (n % 13)), ~lfsr);
      m = model(lfsr[3], lfsr[7], lfsr & (lfsr >> (n % 13)));
      full_check(lfsr[3] ? "R2 sweep" : "R1 sweep", m[5], m[5] ? 32'(m[4:0]) : ~lfsr);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule